// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block starts and ends a parallel section for a pool of thread control units (TCUs). A master unit sends a spawn carrying an inclusive thread-ID range, `spawn_lo` to `spawn_hi`, through a valid/ready handshake. Once the spawn is accepted the dispatcher leaves serial mode and, for one launch cycle, broadcasts the range to every TCU. In the same cycle it gives each TCU a first thread ID equal to `spawn_lo` plus that TCU's index.

After that, each TCU claims further IDs from a shared counter. The counter starts at `spawn_lo + NUM_TCU`, and each claim is an atomic fetch-and-add. Requests that arrive in the same cycle are all served at once with consecutive IDs, so no TCU waits on another. A TCU whose ID lies above `spawn_hi` runs nothing and raises its done flag. When every done flag is high, the dispatcher enters join. It holds `join_done` until the master acknowledges it, and then returns to serial mode.

Back-pressure rules:
- The spawn handshake completes on a clock edge where `spawn_valid` and `spawn_ready` are both high.
- `spawn_ready` is high only in serial mode.
- An ID request is a single-cycle pulse, and every accepted request is answered.
- A TCU must not pulse again until its grant has arrived.

Top module: `tdisp_top`

## Requirements
- R1: `spawn_ready` is high exactly while `parallel_mode` is low. A spawn is accepted on an edge with `spawn_valid` and `spawn_ready` both high, and `parallel_mode` is high from the next cycle on.
- R2: In the cycle after acceptance, `spawn_start` is high for exactly one cycle. In that cycle `bcast_lo`/`bcast_hi` carry the accepted range, `tid_val[i]` equals `spawn_lo + i` for every TCU i, and `tid_gnt` is all zero.
- R3: In the run phase, a request pulse on `tid_req[i]` in cycle t produces `tid_gnt[i]` high in cycle t+1, with `tid_val[i]` holding the claimed ID. The first ID claimed after a spawn is `spawn_lo + NUM_TCU`.
- R4: Requests that arrive in the same cycle receive distinct consecutive IDs, assigned in ascending TCU-index order. The next claim continues after the largest of them.
- R5: Requests made in serial mode or in the launch cycle are ignored: no grant follows and the counter does not move.
- R6: `join_done` rises one cycle after a run-phase edge on which all `tcu_done` bits are high. It stays high until an edge with `join_ack` high, and serial mode returns in the next cycle.
- R7: With TCUs that claim IDs until they pass the bound, every ID in the range is executed exactly once, whatever the per-thread run times.
- R8: An empty range (`spawn_hi < spawn_lo`) still completes the join. No ID is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_valid | input | 1 | Master offers a spawn |
| spawn_ready | output | 1 | Dispatcher can accept a spawn (serial mode) |
| spawn_lo | input | TID_W | First thread ID of the range |
| spawn_hi | input | TID_W | Last thread ID of the range (inclusive) |
| spawn_start | output | 1 | One-cycle launch pulse to all TCUs |
| bcast_lo | output | TID_W | Broadcast lower bound |
| bcast_hi | output | TID_W | Broadcast upper bound |
| parallel_mode | output | 1 | High from launch until join is acknowledged |
| tid_req | input | NUM_TCU | Per-TCU single-cycle ID request |
| tid_gnt | output | NUM_TCU | Per-TCU grant strobe |
| tid_val | output | NUM_TCU x TID_W | Per-TCU thread ID (initial or granted) |
| tcu_done | input | NUM_TCU | Per-TCU done flag |
| join_done | output | 1 | All TCUs finished; held until acknowledged |
| join_ack | input | 1 | Master acknowledges the join |

## Verification
Every result is checked at a negative edge, in the cycle where the bench expects it:
- The launch pulse, broadcast range and initial IDs are checked in the cycle right after the accepting edge.
- A grant, with its ID, is checked one cycle after the request pulse.
- `join_done` is checked one cycle after the last done flag is sampled.
- The return to serial mode is checked one cycle after the acknowledge.

Directed phases drive requests and done flags by hand to pin down these latencies and the ordering of same-cycle claims. A table of ranges then runs a TCU model with uneven run times and counts how many times each ID is executed.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
  typedef enum logic [1:0] {
    PH_SERIAL = 2'd0,
    PH_LAUNCH = 2'd1,
    PH_RUN    = 2'd2,
    PH_JOIN   = 2'd3
  } phase_t;
endpackage

// File: rtl/tdisp_phase_fsm.sv
module tdisp_phase_fsm
  import tdisp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   spawn_fire,
  input  logic   all_done,
  input  logic   join_ack,
  output phase_t phase
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_SERIAL: if (spawn_fire) nxt = PH_LAUNCH;
      PH_LAUNCH: nxt = PH_RUN;
      PH_RUN:    if (all_done) nxt = PH_JOIN;
      PH_JOIN:   if (join_ack) nxt = PH_SERIAL;
      default:   nxt = PH_SERIAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_SERIAL;
    else        phase <= nxt;
  end
endmodule

// File: rtl/tdisp_claim.sv
module tdisp_claim #(
  parameter int NUM_TCU = 8,
  parameter int TID_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [TID_W-1:0]                load_lo,
  input  logic                            enable,
  input  logic [NUM_TCU-1:0]              req,
  output logic [NUM_TCU-1:0]              gnt,
  output logic [NUM_TCU-1:0][TID_W-1:0]   vals
);
  localparam int CNT_W = $clog2(NUM_TCU + 1);

  logic [TID_W-1:0] ctr;
  logic [CNT_W-1:0] pre [NUM_TCU+1];

  // running count of requesters below each lane gives its offset
  always_comb begin
    pre[0] = '0;
    for (int i = 0; i < NUM_TCU; i++)
      pre[i+1] = pre[i] + CNT_W'(req[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctr <= '0;
    else if (load)   ctr <= load_lo + TID_W'(NUM_TCU);
    else if (enable) ctr <= ctr + TID_W'(pre[NUM_TCU]);
  end

  for (genvar gi = 0; gi < NUM_TCU; gi++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gnt[gi]  <= 1'b0;
        vals[gi] <= '0;
      end else if (load) begin
        gnt[gi]  <= 1'b0;
        vals[gi] <= load_lo + TID_W'(gi);
      end else begin
        gnt[gi] <= enable & req[gi];
        if (enable && req[gi]) vals[gi] <= ctr + TID_W'(pre[gi]);
      end
    end
  end
endmodule

// File: rtl/tdisp_top.sv
module tdisp_top
  import tdisp_pkg::*;
#(
  parameter int NUM_TCU = 8,
  parameter int TID_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            spawn_valid,
  output logic                            spawn_ready,
  input  logic [TID_W-1:0]                spawn_lo,
  input  logic [TID_W-1:0]                spawn_hi,
  output logic                            spawn_start,
  output logic [TID_W-1:0]                bcast_lo,
  output logic [TID_W-1:0]                bcast_hi,
  output logic                            parallel_mode,
  input  logic [NUM_TCU-1:0]              tid_req,
  output logic [NUM_TCU-1:0]              tid_gnt,
  output logic [NUM_TCU-1:0][TID_W-1:0]   tid_val,
  input  logic [NUM_TCU-1:0]              tcu_done,
  output logic                            join_done,
  input  logic                            join_ack
);
  phase_t phase;
  logic   spawn_fire;

  assign spawn_ready   = (phase == PH_SERIAL);
  assign spawn_fire    = spawn_valid & spawn_ready;
  assign spawn_start   = (phase == PH_LAUNCH);
  assign parallel_mode = (phase != PH_SERIAL);
  assign join_done     = (phase == PH_JOIN);

  tdisp_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .spawn_fire (spawn_fire),
    .all_done   (&tcu_done),
    .join_ack   (join_ack),
    .phase      (phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcast_lo <= '0;
      bcast_hi <= '0;
    end else if (spawn_fire) begin
      bcast_lo <= spawn_lo;
      bcast_hi <= spawn_hi;
    end
  end

  tdisp_claim #(.NUM_TCU(NUM_TCU), .TID_W(TID_W)) u_claim (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (spawn_fire),
    .load_lo (spawn_lo),
    .enable  (phase == PH_RUN),
    .req     (tid_req),
    .gnt     (tid_gnt),
    .vals    (tid_val)
  );
endmodule

// File: rtl/tdisp_checker.sv
module tdisp_checker #(
  parameter int NUM_TCU = 8,
  parameter int TID_W   = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            spawn_valid,
  input logic                            spawn_ready,
  input logic                            spawn_start,
  input logic                            parallel_mode,
  input logic [NUM_TCU-1:0]              tid_req,
  input logic [NUM_TCU-1:0]              tid_gnt,
  input logic [NUM_TCU-1:0][TID_W-1:0]   tid_val,
  input logic [NUM_TCU-1:0]              tcu_done,
  input logic                            join_done,
  input logic                            join_ack
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_valid && spawn_ready |=> parallel_mode && spawn_start);

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_start |=> !spawn_start);

  p_serial_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !parallel_mode |-> tid_gnt == '0);

  p_join_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_done && !join_ack |=> join_done);

  p_join_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_done && join_ack |=> !parallel_mode);

  p_join_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(join_done) |-> $past(&tcu_done));

  for (genvar gi = 0; gi < NUM_TCU; gi++) begin : g_lane
    p_gnt_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tid_gnt[gi] |-> $past(tid_req[gi]));
  end

  for (genvar gj = 0; gj + 1 < NUM_TCU; gj++) begin : g_pair
    p_consec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tid_gnt[gj] && tid_gnt[gj+1] |-> tid_val[gj+1] == tid_val[gj] + TID_W'(1));
  end
endmodule

bind tdisp_top tdisp_checker #(.NUM_TCU(NUM_TCU), .TID_W(TID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spawn_valid   (spawn_valid),
  .spawn_ready   (spawn_ready),
  .spawn_start   (spawn_start),
  .parallel_mode (parallel_mode),
  .tid_req       (tid_req),
  .tid_gnt       (tid_gnt),
  .tid_val       (tid_val),
  .tcu_done      (tcu_done),
  .join_done     (join_done),
  .join_ack      (join_ack)
);

// File: tb/sim_tdisp_top.sv
module sim_tdisp_top;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int W     = 32;
  localparam int NT    = 5;
  localparam int unsigned LO_T   [NT] = '{0, 0, 10, 5, 1000};
  localparam int unsigned HI_T   [NT] = '{0, 63, 12, 4, 1040};
  localparam int unsigned SEED_T [NT] = '{1, 3, 2, 1, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spawn_valid = 1'b0, spawn_ready, spawn_start, parallel_mode, join_done;
  logic join_ack = 1'b0;
  logic [W-1:0] spawn_lo = '0, spawn_hi = '0, bcast_lo, bcast_hi;
  logic [N-1:0] tid_req, tid_gnt, tcu_done;
  logic [N-1:0][W-1:0] tid_val;

  logic auto_on = 1'b0;
  logic [N-1:0] d_req = '0, d_done = '0, m_req = '0, m_done = '1;
  assign tid_req  = auto_on ? m_req  : d_req;
  assign tcu_done = auto_on ? m_done : d_done;

  int checks = 0, errors = 0;
  int exec_cnt [64];
  int stray = 0;
  logic [W-1:0] cur_lo = '0, cur_hi = '0;
  int seed = 1;
  int busy [N];
  logic [N-1:0] waiting = '0;

  always #(CLK_P/2) clk = ~clk;

  tdisp_top #(.NUM_TCU(N), .TID_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_ready(spawn_ready),
    .spawn_lo(spawn_lo), .spawn_hi(spawn_hi), .spawn_start(spawn_start),
    .bcast_lo(bcast_lo), .bcast_hi(bcast_hi), .parallel_mode(parallel_mode),
    .tid_req(tid_req), .tid_gnt(tid_gnt), .tid_val(tid_val),
    .tcu_done(tcu_done), .join_done(join_done), .join_ack(join_ack)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic exec_id(input logic [W-1:0] id);
    if (id - cur_lo < 64) exec_cnt[id - cur_lo]++;
    else stray++;
  endtask

  // TCU model: runs each thread for a few cycles, then claims another ID
  always @(negedge clk) begin
    if (auto_on) begin
      for (int i = 0; i < N; i++) begin
        logic [W-1:0] id;
        m_req[i] = 1'b0;
        if (spawn_start) begin
          id = tid_val[i];
          waiting[i] = 1'b0;
          if (id > cur_hi) m_done[i] = 1'b1;
          else begin m_done[i] = 1'b0; exec_id(id); busy[i] = int'((id * seed) % 4); end
        end else if (parallel_mode && !m_done[i]) begin
          if (tid_gnt[i]) begin
            id = tid_val[i];
            waiting[i] = 1'b0;
            if (id > cur_hi) m_done[i] = 1'b1;
            else begin exec_id(id); busy[i] = int'((id * seed) % 4); end
          end else if (!waiting[i]) begin
            if (busy[i] == 0) begin m_req[i] = 1'b1; waiting[i] = 1'b1; end
            else busy[i]--;
          end
        end
      end
    end
  end

  task automatic do_spawn(input logic [W-1:0] lo, input logic [W-1:0] hi);
    @(negedge clk);
    spawn_lo = lo; spawn_hi = hi; spawn_valid = 1'b1;
    @(negedge clk);
    spawn_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spawn_ready && !parallel_mode, "R1 reset ready/serial", W'(spawn_ready), 1);
    check(!join_done && tid_gnt == 0, "R6 reset join_done/gnt", W'(join_done), 0);

    // R5 requests in serial mode ignored
    d_req = '1;
    @(negedge clk);
    check(tid_gnt == 0, "R5 no grant in serial", W'(tid_gnt), 0);
    d_req = '0;

    // R1/R2 launch
    do_spawn(32'd100, 32'd200);
    check(spawn_start && parallel_mode && !spawn_ready, "R1 R2 launch state", W'(spawn_start), 1);
    check(bcast_lo == 100 && bcast_hi == 200, "R2 broadcast range", bcast_lo, 100);
    for (int i = 0; i < N; i++)
      check(tid_val[i] == W'(100 + i), "R2 initial id", tid_val[i], W'(100 + i));
    check(tid_gnt == 0, "R2 no grant at launch", W'(tid_gnt), 0);
    d_req = '1;  // launch-cycle requests must be ignored (R5)
    @(negedge clk);
    check(tid_gnt == 0 && !spawn_start, "R5 launch req ignored", W'(tid_gnt), 0);

    // R3 single claim: first dynamic ID is lo+N
    d_req = 8'b0010_0000;
    @(negedge clk);
    d_req = 8'b0100_1010;
    check(tid_gnt == 8'b0010_0000, "R3 grant strobe", W'(tid_gnt), 32'h20);
    check(tid_val[5] == 108, "R3 R5 first claimed id", tid_val[5], 108);
    @(negedge clk);
    d_req = '1;
    check(tid_gnt == 8'b0100_1010, "R4 grant set", W'(tid_gnt), 32'h4a);
    check(tid_val[1] == 109 && tid_val[3] == 110 && tid_val[6] == 111, "R4 ascending ids",
          tid_val[6], 111);
    @(negedge clk);
    d_req = '0;
    for (int i = 0; i < N; i++)
      check(tid_val[i] == W'(112 + i), "R4 full-width claim", tid_val[i], W'(112 + i));

    // R6 join timing
    d_done = 8'h7F;
    @(negedge clk);
    check(!join_done, "R6 partial done no join", W'(join_done), 0);
    d_done = 8'hFF;
    @(negedge clk);
    check(join_done, "R6 join one cycle after all done", W'(join_done), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(join_done && parallel_mode, "R6 join held", W'(join_done), 1);
    end
    join_ack = 1'b1;
    @(negedge clk);
    join_ack = 1'b0;
    check(!parallel_mode && spawn_ready && !join_done, "R6 serial after ack", W'(parallel_mode), 0);
    d_done = '0;

    // R7/R8 table-driven runs with the TCU model
    auto_on = 1'b1;
    for (int t = 0; t < NT; t++) begin
      int span, bad, cyc;
      cur_lo = LO_T[t]; cur_hi = HI_T[t]; seed = int'(SEED_T[t]);
      for (int j = 0; j < 64; j++) exec_cnt[j] = 0;
      stray = 0;
      do_spawn(cur_lo, cur_hi);
      cyc = 0;
      while (!join_done && cyc < 2000) begin @(negedge clk); cyc++; end
      check(join_done, "R7 R8 join reached", W'(join_done), 1);
      join_ack = 1'b1;
      @(negedge clk);
      join_ack = 1'b0;
      check(!parallel_mode, "R6 back to serial", W'(parallel_mode), 0);
      span = (cur_hi >= cur_lo) ? int'(cur_hi - cur_lo + 1) : 0;
      bad = stray;
      for (int j = 0; j < 64; j++) begin
        if (j < span && exec_cnt[j] != 1) bad++;
        if (j >= span && exec_cnt[j] != 0) bad++;
      end
      check(bad == 0, (span == 0) ? "R8 empty range nothing run" : "R7 each id once",
            W'(bad), 0);
    end
    auto_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule